// File: doc/BRIEF.md
# Timer Interrupt Flag Register

This block holds the eight interrupt event flags of a timer subsystem in one byte that software can read. Four of the flags belong to a 16-bit timer: counter wrap (overflow), compare channel A, compare channel B and input capture. The other four take set pulses from two neighbouring 8-bit timers. The timer logic sends each event as a one-cycle pulse. A flag stays set until software writes a one to its bit, or until the interrupt controller acknowledges that flag's vector.

Flags can only be set on cycles where the timer prescaler tick is active. Bus writes and acknowledges work on every system clock cycle. The waveform mode code selects the event that sets the overflow flag and the event that sets the capture flag. A compare match is held back by one timer tick before it sets its flag. A match that a forced-compare strobe produces never sets a flag. Each flag is ANDed with an enable mask to form a request line. A small encoder picks the most urgent pending request of the 16-bit timer.

Top module: `tmr_irq_flags`

## Requirements
- R1: After reset, `rd_data`, `irq_req` and `t1_irq_valid` are all zero.
- R2: Bit 0 follows `oth_set[0]`, bit 1 follows `oth_set[1]`, bit 2 follows `oth_set[2]` and bit 4 follows `oth_set[3]`. On a tick cycle, a pulse sets its bit at the next clock edge.
- R3: Writing with `wr_en` high clears every flag whose `wr_data` bit is one, on any cycle. Flags whose `wr_data` bit is zero keep their value.
- R4: A high `ack[i]` clears flag `i` at the next edge, on any cycle.
- R5: If a flag is set and cleared (by a write or an acknowledge) on the same cycle, the flag ends up set.
- R6: An event that arrives while `tick` is low has no effect. With `tick`, `wr_en` and `ack` all idle, the flags hold their value.
- R7: `cmp_match[0]` on one tick cycle sets bit 6 at the edge of the next tick cycle, and not earlier. `cmp_match[1]` does the same for bit 5.
- R8: A match that arrives together with `cmp_force[k]` never sets its compare flag.
- R9: Bit 7 is set by `ev_wrap` in mode codes 0, 4 and 12. In every other code it is set by `ev_top_alt`.
- R10: Bit 3 is set by `ev_at_top` in mode codes 8, 10, 12 and 14. In every other code it is set by `ev_cap_edge`.
- R11: `irq_req` equals the flag byte ANDed with `irq_en`.
- R12: `t1_irq_valid` is high when any of requests 3, 6, 5 or 7 is high. `t1_irq_id` then names the winner in the order capture (0), compare A (1), compare B (2), overflow (3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timer prescaler tick; flags can only be set when it is high |
| wr_en | input | 1 | Bus write strobe for the flag byte |
| wr_data | input | 8 | Write data; a one in a bit clears that flag |
| rd_data | output | 8 | Current flag byte |
| wave_mode | input | MODE_W | Waveform mode code |
| ev_wrap | input | 1 | Counter wrapped past its maximum |
| ev_top_alt | input | 1 | Overflow set point that depends on the mode |
| ev_cap_edge | input | 1 | Capture edge detected |
| ev_at_top | input | 1 | Counter reached TOP |
| cmp_match | input | 2 | Compare equality, [0]=A, [1]=B |
| cmp_force | input | 2 | Forced-compare strobe, [0]=A, [1]=B |
| oth_set | input | 4 | Set pulses for bits 0, 1, 2, 4 |
| ack | input | 8 | Vector acknowledge, one bit per flag |
| irq_en | input | 8 | Interrupt enable mask |
| irq_req | output | 8 | Masked interrupt requests |
| t1_irq_valid | output | 1 | A 16-bit timer request is pending |
| t1_irq_id | output | 2 | Winning 16-bit timer source |

## Verification
The bench uses the default parameters: a 4-bit mode code with the default mode tables. At that size all 16 mode codes can be driven against all four overflow and capture sources, and the bench derives the expected source from the code value. A 4-bit code together with the 8-bit flag byte also lets the bench try every write-clear pattern and every enable mask once, from a state with all flags set. Separate sequences cover the tick timing of the compare delay and collisions between setting and clearing a flag.

// File: rtl/tif_pkg.sv
package tif_pkg;
    localparam int FLAG_W   = 8;
    localparam int NCMP     = 2;
    localparam int OTH_N    = 4;

    localparam int B_T1_OVF = 7;
    localparam int B_CMP_A  = 6;
    localparam int B_CMP_B  = 5;
    localparam int B_T2_CMP = 4;
    localparam int B_CAP    = 3;
    localparam int B_T2_OVF = 2;
    localparam int B_T0_OVF = 1;
    localparam int B_T0_CMP = 0;

    typedef enum logic [1:0] {
        SRC_CAP  = 2'd0,
        SRC_CMPA = 2'd1,
        SRC_CMPB = 2'd2,
        SRC_OVF  = 2'd3
    } t1_src_e;

    typedef struct packed {
        logic [FLAG_W-1:0] flags;
        logic [NCMP-1:0]   pend;
    } tif_state_t;
endpackage

// File: rtl/tif_mode_decode.sv
module tif_mode_decode #(
    parameter int MODE_W = 4,
    parameter logic [(1<<MODE_W)-1:0] STD_OVF_MODES = '0,
    parameter logic [(1<<MODE_W)-1:0] CAP_TOP_MODES = '0
) (
    input  logic [MODE_W-1:0] mode,
    output logic              std_ovf,
    output logic              cap_top
);
    always_comb begin
        std_ovf = STD_OVF_MODES[mode];
        cap_top = CAP_TOP_MODES[mode];
    end
endmodule

// File: rtl/tif_flag_next.sv
module tif_flag_next (
    input  logic flag_q,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_d
);
    // a set in the same cycle as a clear wins
    always_comb flag_d = set_i | (flag_q & ~clr_i);
endmodule

// File: rtl/tif_prio.sv
module tif_prio
    import tif_pkg::*;
(
    input  logic    req_cap,
    input  logic    req_cmpa,
    input  logic    req_cmpb,
    input  logic    req_ovf,
    output logic    valid,
    output t1_src_e id
);
    always_comb begin
        valid = req_cap | req_cmpa | req_cmpb | req_ovf;
        if (req_cap)       id = SRC_CAP;
        else if (req_cmpa) id = SRC_CMPA;
        else if (req_cmpb) id = SRC_CMPB;
        else               id = SRC_OVF;
    end
endmodule

// File: rtl/tmr_irq_flags.sv
module tmr_irq_flags
    import tif_pkg::*;
#(
    parameter int MODE_W = 4,
    parameter logic [(1<<MODE_W)-1:0] STD_OVF_MODES = 16'h1011,
    parameter logic [(1<<MODE_W)-1:0] CAP_TOP_MODES = 16'h5500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    input  logic [MODE_W-1:0] wave_mode,
    input  logic              ev_wrap,
    input  logic              ev_top_alt,
    input  logic              ev_cap_edge,
    input  logic              ev_at_top,
    input  logic [1:0]        cmp_match,
    input  logic [1:0]        cmp_force,
    input  logic [3:0]        oth_set,
    input  logic [7:0]        ack,
    input  logic [7:0]        irq_en,
    output logic [7:0]        irq_req,
    output logic              t1_irq_valid,
    output logic [1:0]        t1_irq_id
);
    tif_state_t        state_q, state_d;
    logic              std_ovf, cap_top;
    logic [FLAG_W-1:0] evt, set_v, clr_v, flag_nxt;
    logic [NCMP-1:0]   pend_nxt;
    t1_src_e           win_id;

    tif_mode_decode #(
        .MODE_W(MODE_W),
        .STD_OVF_MODES(STD_OVF_MODES),
        .CAP_TOP_MODES(CAP_TOP_MODES)
    ) u_mode (
        .mode(wave_mode),
        .std_ovf(std_ovf),
        .cap_top(cap_top)
    );

    // compare matches wait one timer tick in a pending stage
    for (genvar k = 0; k < NCMP; k++) begin : g_cmp
        always_comb pend_nxt[k] = tick ? (cmp_match[k] & ~cmp_force[k])
                                       : state_q.pend[k];
    end

    always_comb begin
        evt            = '0;
        evt[B_T1_OVF]  = std_ovf ? ev_wrap : ev_top_alt;
        evt[B_CMP_A]   = state_q.pend[0];
        evt[B_CMP_B]   = state_q.pend[1];
        evt[B_CAP]     = cap_top ? ev_at_top : ev_cap_edge;
        evt[B_T0_CMP]  = oth_set[0];
        evt[B_T0_OVF]  = oth_set[1];
        evt[B_T2_OVF]  = oth_set[2];
        evt[B_T2_CMP]  = oth_set[3];
        set_v          = evt & {FLAG_W{tick}};
        clr_v          = ack | (wr_en ? wr_data : '0);
    end

    for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
        tif_flag_next u_nxt (
            .flag_q(state_q.flags[i]),
            .set_i(set_v[i]),
            .clr_i(clr_v[i]),
            .flag_d(flag_nxt[i])
        );
    end

    always_comb begin
        state_d       = state_q;
        state_d.flags = flag_nxt;
        state_d.pend  = pend_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    always_comb begin
        rd_data = state_q.flags;
        irq_req = state_q.flags & irq_en;
    end

    tif_prio u_prio (
        .req_cap(irq_req[B_CAP]),
        .req_cmpa(irq_req[B_CMP_A]),
        .req_cmpb(irq_req[B_CMP_B]),
        .req_ovf(irq_req[B_T1_OVF]),
        .valid(t1_irq_valid),
        .id(win_id)
    );

    always_comb t1_irq_id = win_id;
endmodule

// File: rtl/tif_chk.sv
module tif_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] ack,
    input logic [3:0] oth_set,
    input logic [7:0] rd_data,
    input logic [7:0] irq_req,
    input logic       t1_irq_valid,
    input logic [1:0] t1_irq_id
);
    a_r1_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (rd_data == 8'h00));

    for (genvar i = 0; i < 8; i++) begin : g_bit
        a_r3_w1c: assert property (@(posedge clk) disable iff (!rst_n)
            (!tick && wr_en && wr_data[i]) |=> !rd_data[i]);
        a_r4_ack: assert property (@(posedge clk) disable iff (!rst_n)
            (!tick && ack[i]) |=> !rd_data[i]);
    end

    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_en && (ack == 8'h00)) |=> $stable(rd_data));

    a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && oth_set[0]) |=> rd_data[0]);

    a_r12_cap_first: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req[3] |-> (t1_irq_valid && t1_irq_id == 2'd0));

    a_r12_valid_src: assert property (@(posedge clk) disable iff (!rst_n)
        t1_irq_valid |-> ((irq_req & 8'hE8) != 8'h00));
endmodule

bind tmr_irq_flags tif_chk u_chk (
    .clk(clk),
    .rst_n(rst_n),
    .tick(tick),
    .wr_en(wr_en),
    .wr_data(wr_data),
    .ack(ack),
    .oth_set(oth_set),
    .rd_data(rd_data),
    .irq_req(irq_req),
    .t1_irq_valid(t1_irq_valid),
    .t1_irq_id(t1_irq_id)
);

// File: tb/test_tmr_irq_flags.sv
module test_tmr_irq_flags;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick, wr_en, ev_wrap, ev_top_alt, ev_cap_edge, ev_at_top;
    logic [7:0] wr_data, ack, irq_en, rd_data, irq_req;
    logic [3:0] wave_mode, oth_set;
    logic [1:0] cmp_match, cmp_force, t1_irq_id;
    logic       t1_irq_valid;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    tmr_irq_flags i_tmr_irq_flags (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .wave_mode(wave_mode),
        .ev_wrap(ev_wrap), .ev_top_alt(ev_top_alt), .ev_cap_edge(ev_cap_edge),
        .ev_at_top(ev_at_top), .cmp_match(cmp_match), .cmp_force(cmp_force),
        .oth_set(oth_set), .ack(ack), .irq_en(irq_en), .irq_req(irq_req),
        .t1_irq_valid(t1_irq_valid), .t1_irq_id(t1_irq_id)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle();
        tick = 0; wr_en = 0; wr_data = '0; ack = '0;
        ev_wrap = 0; ev_top_alt = 0; ev_cap_edge = 0; ev_at_top = 0;
        cmp_match = '0; cmp_force = '0; oth_set = '0;
    endtask

    // inputs are set at a falling edge; one rising edge; back to falling edge
    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic clear_all();
        wr_en = 1; wr_data = 8'hFF; cyc();
    endtask

    task automatic set_all();
        wave_mode = 4'd0;
        tick = 1; oth_set = 4'hF; ev_wrap = 1; ev_cap_edge = 1; cmp_match = 2'b11;
        cyc();
        tick = 1; cyc();
    endtask

    initial begin
        idle();
        wave_mode = 4'd0; irq_en = 8'h00;
        repeat (3) @(negedge clk);
        chk("R1 flags", rd_data, 8'h00);
        chk("R1 req", irq_req, 8'h00);
        chk("R1 valid", t1_irq_valid, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", rd_data, 8'h00);

        // R2 / R6: other-timer set pulses
        for (int k = 0; k < 4; k++) begin
            logic [7:0] m;
            m = (k == 3) ? 8'h10 : (8'h01 << k);
            oth_set[k] = 1'b1; cyc();
            chk("R6 no tick", rd_data, 8'h00);
            tick = 1; oth_set[k] = 1'b1; cyc();
            chk("R2 bit map", rd_data, m);
            repeat (2) cyc();
            chk("R6 hold", rd_data, m);
            clear_all();
        end

        set_all();
        chk("R2 all set", rd_data, 8'hFF);

        // R3: every write pattern
        for (int v = 0; v < 256; v++) begin
            set_all();
            wr_en = 1; wr_data = v[7:0]; cyc();
            chk("R3 w1c", rd_data, 8'hFF & ~v[7:0]);
        end

        // R4: acknowledge each vector
        for (int i = 0; i < 8; i++) begin
            set_all();
            ack = 8'h01 << i; cyc();
            chk("R4 ack", rd_data, 8'hFF & ~(8'h01 << i));
        end

        // R5: set beats clear
        clear_all();
        tick = 1; oth_set = 4'b0001; wr_en = 1; wr_data = 8'hFF; ack = 8'hFF; cyc();
        chk("R5 set wins", rd_data, 8'h01);
        clear_all();
        tick = 1; cmp_match = 2'b01; cyc();
        tick = 1; wr_en = 1; wr_data = 8'hFF; cyc();
        chk("R5 cmp set wins", rd_data, 8'h40);
        clear_all();

        // R7: compare delay of one tick
        for (int k = 0; k < 2; k++) begin
            logic [7:0] m;
            m = (k == 0) ? 8'h40 : 8'h20;
            tick = 1; cmp_match[k] = 1'b1; cyc();
            chk("R7 not same tick", rd_data, 8'h00);
            repeat (3) cyc();
            chk("R7 waits for tick", rd_data, 8'h00);
            tick = 1; cyc();
            chk("R7 next tick", rd_data, m);
            clear_all();
            // R8: forced strobe does not set
            tick = 1; cmp_match[k] = 1'b1; cmp_force[k] = 1'b1; cyc();
            tick = 1; cyc();
            tick = 1; cyc();
            chk("R8 force ignored", rd_data, 8'h00);
        end

        // R9 / R10: every mode code against every source
        for (int md = 0; md < 16; md++) begin
            logic std, ctop;
            std  = (md == 0) || (md == 4) || (md == 12);
            ctop = (md >= 8) && (md % 2 == 0);
            clear_all();
            wave_mode = md[3:0]; tick = 1; ev_wrap = 1; cyc();
            chk("R9 wrap", rd_data, {std, 7'b0});
            clear_all();
            wave_mode = md[3:0]; tick = 1; ev_top_alt = 1; cyc();
            chk("R9 alt", rd_data, {!std, 7'b0});
            clear_all();
            wave_mode = md[3:0]; tick = 1; ev_cap_edge = 1; cyc();
            chk("R10 edge", rd_data, {4'b0, !ctop, 3'b0});
            clear_all();
            wave_mode = md[3:0]; tick = 1; ev_at_top = 1; cyc();
            chk("R10 top", rd_data, {4'b0, ctop, 3'b0});
        end

        // R11 / R12: every enable mask with all flags set
        set_all();
        for (int e = 0; e < 256; e++) begin
            logic [1:0] exp_id;
            logic       exp_v;
            irq_en = e[7:0];
            @(negedge clk);
            exp_v  = (e[3] | e[6] | e[5] | e[7]);
            exp_id = e[3] ? 2'd0 : e[6] ? 2'd1 : e[5] ? 2'd2 : 2'd3;
            chk("R11 mask", irq_req, e[7:0]);
            chk("R12 valid", t1_irq_valid, exp_v);
            if (exp_v) chk("R12 priority", t1_irq_id, exp_id);
        end

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule